// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Result Registers

This unit sits beside the integer pipeline of a 32-bit load/store core and holds the two result registers that multiply and divide operations fill. A one-cycle start pulse, an operation code and two operands launch an operation. Multiplication finishes in a single cycle. Division runs as a bit-serial restoring loop of one quotient bit per cycle, and `busy_o` stays high until the loop has written its result.

Some operand pairs have no meaningful quotient: a zero divisor, and the most negative value divided by minus one. The unit gives these fixed results, and it writes them in the cycle after the start, with no iteration. The core can also load either result register directly from a data input, which is used for context restore.

Top module: `md_unit`

## Requirements
- R1: While `rst_ni` is low, `hi_o`, `lo_o` and `busy_o` are all zero.
- R2: The operation code on `op_i` is 0 = signed multiply, 1 = unsigned multiply, 2 = signed divide and 3 = unsigned divide. With code 0 accepted, the edge after the start puts the low half of the 64-bit two's-complement product into `lo_o` and the high half into `hi_o`, and `busy_o` stays low.
- R3: With code 1 accepted, the product of the zero-extended operands is written in the same way in the next cycle, and `busy_o` stays low.
- R4: With code 2 accepted and a normal operand pair, `busy_o` is high for exactly 32 cycles after the start edge. When it falls, `lo_o` holds the quotient truncated toward zero and `hi_o` holds the remainder, which carries the sign of the dividend.
- R5: With code 3 accepted and a nonzero divisor, the timing is the same as R4, and `lo_o`/`hi_o` get the unsigned quotient and remainder.
- R6: A signed divide by zero completes in one cycle without raising `busy_o`. It sets `hi_o` to the dividend, and sets `lo_o` to 1 when the dividend is negative and to 0xFFFFFFFF when it is not.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF completes in one cycle without raising `busy_o`, with `lo_o` = 0x80000000 and `hi_o` = 0.
- R8: An unsigned divide by zero completes in one cycle without raising `busy_o`, with `lo_o` = 0xFFFFFFFF and `hi_o` equal to the dividend.
- R9: When the unit is idle and `start_i` is low, `hi_we_i` loads `wdata_i` into `hi_o` and `lo_we_i` loads `wdata_i` into `lo_o` at the next edge. A register whose write enable is low keeps its value.
- R10: While `busy_o` is high, `start_i`, `hi_we_i` and `lo_we_i` are ignored. `hi_o` and `lo_o` keep their previous values until the divide writes its result.
- R11: If a start is accepted in the same cycle as a direct write, the operation result is stored and the direct write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation (one-cycle pulse) |
| op_i | input | 2 | Operation code (see R2) |
| a_i | input | 32 | Multiplicand or dividend |
| b_i | input | 32 | Multiplier or divisor |
| hi_we_i | input | 1 | Direct write to HI |
| lo_we_i | input | 1 | Direct write to LO |
| wdata_i | input | 32 | Data for direct writes |
| busy_o | output | 1 | Divide in progress |
| hi_o | output | 32 | HI register |
| lo_o | output | 32 | LO register |

## Verification
The assertions assume that `op_i`, `a_i` and `b_i` are known and stable in every cycle where `start_i` is high. They also assume that `start_i` is a single-cycle pulse and not a level that is held high. The bench drives every operand in the negedge before a start and clears `start_i` one cycle later. The only held stimulus is the deliberate one in the busy-window test, and it uses legal values. Random divisors are often drawn from a small range so that division by zero and tiny quotients come up often. The fixed-result operand pairs are also driven as directed cases.

// File: rtl/md_pkg.sv
package md_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'd0,
    OP_MUL_U = 2'd1,
    OP_DIV_S = 2'd2,
    OP_DIV_U = 2'd3
  } md_op_e;
endpackage

// File: rtl/md_mult.sv
module md_mult #(
  parameter int W = 32
) (
  input  logic           is_signed_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  localparam int EW = W + 1;

  logic signed [EW-1:0]   a_ext, b_ext;
  logic signed [2*EW-1:0] full;

  // one extension bit picks signed or unsigned interpretation
  assign a_ext  = $signed({is_signed_i & a_i[W-1], a_i});
  assign b_ext  = $signed({is_signed_i & b_i[W-1], b_i});
  assign full   = a_ext * b_ext;
  assign prod_o = full[2*W-1:0];
endmodule

// File: rtl/md_div.sv
module md_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [W:0]    trial;
  logic [W-1:0]  rem_n, quo_n;

  // restoring step: shift in next dividend bit, subtract if it fits
  assign trial = {rem_q, quo_q[W-1]} - {1'b0, den_q};
  assign rem_n = trial[W] ? {rem_q[W-2:0], quo_q[W-1]} : trial[W-1:0];
  assign quo_n = {quo_q[W-2:0], ~trial[W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
    end else if (load_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= num_i;
      den_q  <= den_i;
    end else if (busy_q) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST);
  assign quo_o  = quo_n;
  assign rem_o  = rem_n;
endmodule

// File: rtl/md_unit.sv
module md_unit
  import md_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         hi_we_i,
  input  logic         lo_we_i,
  input  logic [W-1:0] wdata_i,
  output logic         busy_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONE = '1;
  localparam logic [W-1:0] ONE     = W'(1);

  md_op_e       op;
  logic         div_busy, div_done, accept, is_div, sgn;
  logic         b_zero, ovf, neg_a, neg_b, div_load;
  logic [W-1:0] mag_a, mag_b, quo, rem;
  logic [2*W-1:0] prod;
  logic         qneg_q, rneg_q;
  logic [W-1:0] hi_q, lo_q;

  assign op       = md_op_e'(op_i);
  assign accept   = start_i && !div_busy;
  assign is_div   = (op == OP_DIV_S) || (op == OP_DIV_U);
  assign sgn      = (op == OP_MUL_S) || (op == OP_DIV_S);
  assign b_zero   = (b_i == '0);
  assign ovf      = (op == OP_DIV_S) && (a_i == MIN_NEG) && (b_i == ALL_ONE);
  assign neg_a    = sgn && a_i[W-1];
  assign neg_b    = sgn && b_i[W-1];
  assign mag_a    = neg_a ? (~a_i + ONE) : a_i;
  assign mag_b    = neg_b ? (~b_i + ONE) : b_i;
  assign div_load = accept && is_div && !b_zero && !ovf;

  md_mult #(.W(W)) u_mult (
    .is_signed_i (sgn),
    .a_i         (a_i),
    .b_i         (b_i),
    .prod_o      (prod)
  );

  md_div #(.W(W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (div_load),
    .num_i  (mag_a),
    .den_i  (mag_b),
    .busy_o (div_busy),
    .done_o (div_done),
    .quo_o  (quo),
    .rem_o  (rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
    end else if (accept) begin
      if (!is_div) begin
        hi_q <= prod[2*W-1:W];
        lo_q <= prod[W-1:0];
      end else if (b_zero) begin
        hi_q <= a_i;
        lo_q <= neg_a ? ONE : ALL_ONE;
      end else if (ovf) begin
        hi_q <= '0;
        lo_q <= MIN_NEG;
      end else begin
        qneg_q <= neg_a ^ neg_b;
        rneg_q <= neg_a;
      end
    end else if (div_done) begin
      lo_q <= qneg_q ? (~quo + ONE) : quo;
      hi_q <= rneg_q ? (~rem + ONE) : rem;
    end else if (!div_busy) begin
      if (hi_we_i) hi_q <= wdata_i;
      if (lo_we_i) lo_q <= wdata_i;
    end
  end

  assign busy_o = div_busy;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
endmodule

// File: rtl/md_unit_chk.sv
module md_unit_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [1:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         busy_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  localparam int CW = $clog2(W) + 1;

  logic [CW-1:0]    busy_cnt;
  logic [2*W-1:0]   sprod;

  assign sprod = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  // R2
  a_r2_mul_signed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i == 2'd0) |=> ({hi_o, lo_o} == $past(sprod)) && !busy_o);

  // R4
  a_r4_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_cnt < CW'(W)));

  // R4
  a_r4_busy_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(start_i) && $past(op_i[1])));

  // R6
  a_r6_sdiv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i == 2'd2 && b_i == '0) |=>
      !busy_o && hi_o == $past(a_i) && lo_o == ($past(a_i[W-1]) ? W'(1) : '1));

  // R8
  a_r8_udiv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i == 2'd3 && b_i == '0) |=>
      !busy_o && hi_o == $past(a_i) && lo_o == '1);

  // R10
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(hi_o) && $stable(lo_o)));
endmodule

bind md_unit md_unit_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .busy_o  (busy_o),
  .hi_o    (hi_o),
  .lo_o    (lo_o)
);

// File: tb/md_unit_tb.sv
module md_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0, wdata_i = '0;
  logic        hi_we_i = 1'b0, lo_we_i = 1'b0;
  logic        busy_o;
  logic [31:0] hi_o, lo_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  md_unit u_dut (.*);

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, act cycles=%0d exp finish", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sp;
    logic signed [31:0] sa, sb;
    sa = a; sb = b;
    case (op)
      2'd0: begin sp = 64'(sa) * 64'(sb); return sp; end
      2'd1: return {32'd0, a} * {32'd0, b};
      2'd2: begin
        if (b == 0) return {a, (a[31] ? 32'd1 : 32'hFFFF_FFFF)};
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return {32'd0, 32'h8000_0000};
        return {32'(sa % sb), 32'(sa / sb)};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {a % b, a / b};
      end
    endcase
  endfunction

  function automatic string tag(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    if (op == 2'd0) return "R2";
    if (op == 2'd1) return "R3";
    if (op == 2'd2 && b == 0) return "R6";
    if (op == 2'd2 && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R7";
    if (op == 2'd2) return "R4";
    if (b == 0) return "R8";
    return "R5";
  endfunction

  // launch at a negedge, count busy negedges, compare results
  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    int nb;
    int exp_nb;
    logic [63:0] e;
    string t;
    e = model(op, a, b);
    t = tag(op, a, b);
    exp_nb = (t == "R4" || t == "R5") ? 32 : 0;
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    nb = 0;
    while (busy_o && nb < 40) begin
      nb++;
      @(negedge clk_i);
    end
    chk(nb == exp_nb, {t, " busy cycles"}, 64'(nb), 64'(exp_nb));
    chk({hi_o, lo_o} == e, {t, " hi:lo"}, {hi_o, lo_o}, e);
  endtask

  initial begin
    logic [63:0] saved;
    int nb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(hi_o == 0 && lo_o == 0 && busy_o == 0, "R1 reset", {hi_o, lo_o}, 64'd0);
    rst_ni = 1'b1;

    // directed corners
    run_op(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op(2'd0, 32'h8000_0000, 32'h7FFF_FFFF);
    run_op(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op(2'd2, 32'hFFFF_FFF9, 32'd2);
    run_op(2'd2, 32'd7, 32'hFFFF_FFFE);
    run_op(2'd2, 32'h8000_0000, 32'd1);
    run_op(2'd2, 32'hFFFF_FFF0, 32'd0);
    run_op(2'd2, 32'd5, 32'd0);
    run_op(2'd2, 32'h8000_0000, 32'hFFFF_FFFF);
    run_op(2'd3, 32'hFFFF_FFFF, 32'd1);
    run_op(2'd3, 32'd3, 32'hFFFF_FFFF);
    run_op(2'd3, 32'h1234_5678, 32'd0);

    // R9 direct writes while idle
    @(negedge clk_i);
    saved = {hi_o, lo_o};
    hi_we_i = 1'b1; wdata_i = 32'hA5A5_0001;
    @(negedge clk_i);
    hi_we_i = 1'b0;
    chk(hi_o == 32'hA5A5_0001 && lo_o == saved[31:0], "R9 hi write",
        {hi_o, lo_o}, {32'hA5A5_0001, saved[31:0]});
    lo_we_i = 1'b1; wdata_i = 32'h5A5A_0002;
    @(negedge clk_i);
    lo_we_i = 1'b0;
    chk(hi_o == 32'hA5A5_0001 && lo_o == 32'h5A5A_0002, "R9 lo write",
        {hi_o, lo_o}, {32'hA5A5_0001, 32'h5A5A_0002});

    // R11 start with simultaneous write: op wins
    start_i = 1'b1; op_i = 2'd1; a_i = 32'd6; b_i = 32'd7;
    hi_we_i = 1'b1; lo_we_i = 1'b1; wdata_i = 32'hDEAD_BEEF;
    @(negedge clk_i);
    start_i = 1'b0; hi_we_i = 1'b0; lo_we_i = 1'b0;
    chk(hi_o == 0 && lo_o == 32'd42, "R11 start beats write", {hi_o, lo_o}, 64'd42);

    // R10 start and writes ignored while busy; values held
    saved = {hi_o, lo_o};
    start_i = 1'b1; op_i = 2'd3; a_i = 32'd1000; b_i = 32'd7;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b1; op_i = 2'd0; a_i = 32'd3; b_i = 32'd3;
    hi_we_i = 1'b1; lo_we_i = 1'b1; wdata_i = 32'h1111_1111;
    @(negedge clk_i);
    start_i = 1'b0; hi_we_i = 1'b0; lo_we_i = 1'b0;
    chk(busy_o && {hi_o, lo_o} == saved, "R10 hold while busy", {hi_o, lo_o}, saved);
    nb = 0;
    while (busy_o && nb < 40) begin nb++; @(negedge clk_i); end
    chk(hi_o == 32'd6 && lo_o == 32'd142, "R10 busy start ignored",
        {hi_o, lo_o}, {32'd6, 32'd142});

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [1:0]  op;
      logic [31:0] a, b;
      op = 2'($urandom());
      a  = $urandom();
      b  = ($urandom() % 3 == 0) ? 32'($urandom() % 4) : $urandom();
      if ($urandom() % 2 == 0) b = {{16{b[15]}}, b[15:0]};
      run_op(op, a, b);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule